// File: doc/BRIEF.md
# Cascadable Divide-by-N Down Counter Slice

This block is a 4-bit down counter that divides its clock by a value N taken from a parallel preset input. When the zero output is wired back to the preset-enable input, the slice reloads N by itself each time it reaches its terminal state. The zero output then carries a single-cycle pulse once every N clocks.

Slices chain into a wider divider. Each slice's zero output drives the cascade input of the next less-significant slice. The most significant slice has its cascade input tied high. The zero output of the least significant slice drives preset enable on every slice. For the more-significant slices, count inhibit comes from glue logic that holds them while any lower slice is non-zero, so a borrow passes upward only when every lower digit is zero.

Reset is synchronous and active high. In a chain, only the least significant slice needs it.

Top module: `divn_slice`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `count_o` = 0 and `zero_o` = 1. `zero_o` stays high after `rst` falls until a load has taken place.
- R2: At a clock edge where `preset_en_i` is high and `rst` is low, `count_o` takes the value of `preset_i`. With `preset_en_i` tied to `zero_o`, the first edge after reset release loads N.
- R3: After that first load, `zero_o` is low whenever N is 2 or more.
- R4: At an edge where `rst`, `preset_en_i` and `inhibit_i` are all low, `count_o` decreases by one, wrapping from 0 to 15.
- R5: With `TERM_ONE`=1 (least significant slice), `zero_o` is high when `casc_i` is high and `count_o` is 1 or 0. With self-reload and N ≥ 2, this gives a one-cycle pulse every N clocks and a count sequence N, N-1, …, 1.
- R6: At an edge where `inhibit_i` is high and `preset_en_i` is low, `count_o` holds. Each inhibited cycle lengthens the period by one.
- R7: A load takes priority over both inhibit and decrement.
- R8: With N = 1 and self-reload, `zero_o` is high on every cycle and `count_o` stays at 1.
- R9: With N = 0 and self-reload, `zero_o` stays high and `count_o` stays at 0.
- R10: With `TERM_ONE`=0 (upper slice), `zero_o` is high only when `casc_i` is high and `count_o` is 0. A low `casc_i` always forces `zero_o` low, unless a reset-initiated load is still pending.
- R11: In a three-slice chain where reset reaches only the least significant slice, all slices are preset to N. The 12-bit value then counts N, …, 1 and repeats with period N, and the chain's zero output pulses when the value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset and load request |
| inhibit_i | input | 1 | Holds the count when high |
| preset_en_i | input | 1 | Loads `preset_i` on the next edge when high |
| casc_i | input | 1 | High when all more-significant slices are zero |
| preset_i | input | W | Divide value N for this digit |
| count_o | output | W | Current count |
| zero_o | output | 1 | Terminal / zero flag, also the cascade output |

## Verification
The count is a single register, so each load, decrement or hold shows up on `count_o` in the cycle that follows the edge that sampled it. The zero flag is combinational from that register, so it is valid in the same cycle. After reset is released, the first edge loads N, and at edge k the expected count is N − ((k−1) mod N), with the zero flag high exactly when that value is 1. The bench drives inputs and samples outputs at the falling edge, so each check follows exactly one rising edge. Inhibit stretch and reload-over-inhibit are checked by counting edges from reset release to the next zero pulse.

// File: rtl/divn_pkg.sv
package divn_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_DEC   = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    typedef struct packed {
        logic rst;
        logic load;
        logic hold;
    } req_t;

    // Priority: clear over load over hold over decrement.
    function automatic act_e pick_act(input req_t r);
        if (r.rst)       return ACT_CLEAR;
        else if (r.load) return ACT_LOAD;
        else if (r.hold) return ACT_HOLD;
        else             return ACT_DEC;
    endfunction

endpackage

// File: rtl/divn_ctrl.sv
module divn_ctrl
    import divn_pkg::*;
(
    input  logic rst,
    input  logic load_req,
    input  logic hold_req,
    output act_e act_o
);
    req_t req;

    always_comb begin
        req      = '0;
        req.rst  = rst;
        req.load = load_req;
        req.hold = hold_req;
        act_o    = pick_act(req);
    end
endmodule

// File: rtl/divn_state.sv
module divn_state
    import divn_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act_i,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_q,
    output logic         pend_q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_d;
    logic         pend_d;

    always_comb begin
        count_d = count_q;
        pend_d  = pend_q;
        unique case (act_i)
            ACT_CLEAR: begin
                count_d = '0;
                pend_d  = 1'b1;
            end
            ACT_LOAD: begin
                count_d = load_val;
                pend_d  = 1'b0;
            end
            ACT_DEC:  count_d = count_q - ONE;
            ACT_HOLD: count_d = count_q;
            default:  count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        count_q <= count_d;
        pend_q  <= pend_d;
    end

    // R2
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_LOAD) |=> !pend_q);
endmodule

// File: rtl/divn_zero.sv
module divn_zero #(
    parameter int W        = divn_pkg::SLICE_W,
    parameter bit TERM_ONE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count_i,
    input  logic         casc_i,
    input  logic         pend_i,
    output logic         zero_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic match;

    generate
        if (TERM_ONE) begin : g_lsb
            // terminal state 1 gives a period of exactly N; 0 covers N = 0
            assign match = (count_i <= ONE);
        end else begin : g_upper
            assign match = (count_i == '0);
        end
    endgenerate

    assign zero_o = pend_i | (casc_i & match);

    // R10
    casc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!casc_i && !pend_i) |-> !zero_o);
endmodule

// File: rtl/divn_slice.sv
module divn_slice
    import divn_pkg::*;
#(
    parameter int W        = SLICE_W,
    parameter bit TERM_ONE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inhibit_i,
    input  logic         preset_en_i,
    input  logic         casc_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] count_o,
    output logic         zero_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    act_e         act;
    logic [W-1:0] count_q;
    logic         pend_q;

    divn_ctrl u_ctrl (
        .rst      (rst),
        .load_req (preset_en_i),
        .hold_req (inhibit_i),
        .act_o    (act)
    );

    divn_state #(.W(W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .act_i    (act),
        .load_val (preset_i),
        .count_q  (count_q),
        .pend_q   (pend_q)
    );

    divn_zero #(.W(W), .TERM_ONE(TERM_ONE)) u_zero (
        .clk     (clk),
        .rst     (rst),
        .count_i (count_q),
        .casc_i  (casc_i),
        .pend_i  (pend_q),
        .zero_o  (zero_o)
    );

    assign count_o = count_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (zero_o && count_o == '0));

    // R2 R7
    load_chk: assert property (@(posedge clk) disable iff (rst)
        preset_en_i |=> count_o == $past(preset_i));

    // R4
    dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!preset_en_i && !inhibit_i) |=> count_o == $past(count_o) - ONE);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!preset_en_i && inhibit_i) |=> $stable(count_o));
endmodule

// File: tb/divn_slice_bench.sv
module divn_slice_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inh = 1'b0;
    logic [3:0] pv  = 4'd0;
    logic [3:0] cnt;
    logic       zero;

    always #2 clk = ~clk;

    divn_slice #(.W(4), .TERM_ONE(1'b1)) u_divn_slice (
        .clk(clk), .rst(rst), .inhibit_i(inh), .preset_en_i(zero),
        .casc_i(1'b1), .preset_i(pv), .count_o(cnt), .zero_o(zero)
    );

    // three-slice chain, reset on the least significant slice only
    localparam int CN = 12'h123;
    logic       crst = 1'b1;
    logic [3:0] c0, c1, c2;
    logic       z0, z1, z2;
    logic       inh1, inh2;
    assign inh1 = |c0;
    assign inh2 = (|c0) | (|c1);

    divn_slice #(.W(4), .TERM_ONE(1'b1)) u_c0 (
        .clk(clk), .rst(crst), .inhibit_i(1'b0), .preset_en_i(z0),
        .casc_i(z1), .preset_i(CN[3:0]), .count_o(c0), .zero_o(z0));
    divn_slice #(.W(4), .TERM_ONE(1'b0)) u_c1 (
        .clk(clk), .rst(1'b0), .inhibit_i(inh1), .preset_en_i(z0),
        .casc_i(z2), .preset_i(CN[7:4]), .count_o(c1), .zero_o(z1));
    divn_slice #(.W(4), .TERM_ONE(1'b0)) u_c2 (
        .clk(clk), .rst(1'b0), .inhibit_i(inh2), .preset_en_i(z0),
        .casc_i(1'b1), .preset_i(CN[11:8]), .count_o(c2), .zero_o(z2));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart(input int n);
        pv  = 4'(n);
        rst = 1'b1;
        step();
        step();
        chk("R1 zero in reset", int'(zero), 1);
        chk("R1 count in reset", int'(cnt), 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int e, steps;
        @(negedge clk);
        repeat (4) step();
        chk("R1 initial count", int'(cnt), 0);
        chk("R1 initial zero", int'(zero), 1);

        // sweep N = 1..15 with self-reload
        for (int n = 1; n <= 15; n++) begin
            restart(n);
            for (int k = 1; k <= 2 * n + 3; k++) begin
                step();
                e = n - ((k - 1) % n);
                if (n == 1) begin
                    chk("R8 count", int'(cnt), 1);
                    chk("R8 zero", int'(zero), 1);
                end else if (k == 1) begin
                    chk("R2 load count", int'(cnt), n);
                    chk("R3 zero after load", int'(zero), 0);
                end else begin
                    chk("R4 count", int'(cnt), e);
                    chk("R5 zero", int'(zero), (e == 1) ? 1 : 0);
                end
            end
        end

        // N = 0
        restart(0);
        for (int k = 1; k <= 8; k++) begin
            step();
            chk("R9 count", int'(cnt), 0);
            chk("R9 zero", int'(zero), 1);
        end

        // inhibit stretch, N = 9
        restart(9);
        steps = 0;
        repeat (3) begin step(); steps++; end
        chk("R4 count before inhibit", int'(cnt), 7);
        inh = 1'b1;
        repeat (3) begin
            step(); steps++;
            chk("R6 hold", int'(cnt), 7);
        end
        inh = 1'b0;
        while (zero == 1'b0 && steps < 40) begin step(); steps++; end
        chk("R6 stretched period", steps, 12);

        // reload wins over inhibit, N = 4
        restart(4);
        repeat (4) step();
        chk("R5 zero at count 1", int'(zero), 1);
        inh = 1'b1;
        step();
        chk("R7 reload under inhibit", int'(cnt), 4);
        step();
        chk("R6 hold after reload", int'(cnt), 4);
        inh = 1'b0;

        // cascade: reset has been held on the LSB slice only
        chk("R11 preset of all slices", int'({c2, c1, c0}), 12'h120);
        chk("R1 chain zero in reset", int'(z0), 1);
        crst = 1'b0;
        for (int k = 1; k <= 2 * CN + 2; k++) begin
            step();
            e = CN - ((k - 1) % CN);
            chk("R11 chain value", int'({c2, c1, c0}), e);
            chk("R5 chain zero", int'(z0), (e == 1) ? 1 : 0);
            chk("R10 upper zero", int'(z1), ((e >> 4) == 0) ? 1 : 0);
        end

        finish_run();
    end
endmodule